// File: doc/BRIEF.md
# Dual-Mode UART Baud Tick Generator

This block turns the system clock into the timing pulses that a UART transmitter and receiver step on. It emits a per-sample tick at the oversampling rate. From that tick it derives a per-bit tick and a mid-bit strobe, which a receiver uses to pick the centre of each bit.

The sample rate comes from a 16-bit rate setting. It can be produced in two ways:

- **Divisor mode.** A reload counter emits one tick every `setting + 1` clocks. Here the setting is `f_clk / (16 * baud) - 1`.
- **Fractional mode.** A 16-bit phase accumulator adds the setting every clock and ticks on each carry out. Here the setting is `baud * 16 / f_clk * 65536`, which gives a finer rate.

The setting is written as two byte halves, each with its own strobe. A separate strobe loads the mode bits: the source mode and the 8x/16x oversampling choice. Every write restarts the timing chain, so a stale count is never carried across a rate change. While the enable input is low, all timing state is held at zero.

Top module: `baud_tick_gen`

## Requirements
- R1: A high-byte write replaces setting bits 15:8 only. A low-byte write replaces bits 7:0 only. The other half keeps its value. The new setting is in effect from the clock after the write.
- R2: In divisor mode (mode bit 0), `sample_tick` is high for one clock in every `setting + 1` clocks. The first tick comes `setting + 1` clocks after the tick source starts from zero.
- R3: In fractional mode, the setting is added to a 16-bit accumulator every enabled clock. `sample_tick` is high in the clock after each addition that carries out of bit 15. A setting of 0 never ticks.
- R4: Writing the source-mode input as 1 with `mode_we` selects fractional mode. Writing it as 0 selects divisor mode.
- R5: In 8x mode (oversampling input 1), `bit_tick` accompanies every 8th sample tick. `mid_tick` accompanies the 4th sample tick of each bit.
- R6: In 16x mode, `bit_tick` accompanies every 16th sample tick and `mid_tick` the 8th. After reset the block is in 16x divisor mode with setting 0, and all three outputs are low.
- R7: While `enable` is low, the divisor counter, the accumulator and the sample counter are held at zero, and no output is asserted. Counting restarts from zero on the first enabled clock.
- R8: Any write (either byte or the mode bits) clears the divisor counter, the accumulator and the sample counter. It also suppresses the sample tick in the following clock.
- R9: `bit_tick` and `mid_tick` are never high in the same clock. Neither is ever high without `sample_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | UART enable; low holds all timing state at zero |
| rate_hi_we | input | 1 | Write strobe for the upper setting byte |
| rate_hi_data | input | 8 | Upper setting byte |
| rate_lo_we | input | 1 | Write strobe for the lower setting byte |
| rate_lo_data | input | 8 | Lower setting byte |
| mode_we | input | 1 | Write strobe for the mode bits |
| frac_sel | input | 1 | 1 = fractional accumulator, 0 = integer divisor |
| ovs8_sel | input | 1 | 1 = 8x oversampling, 0 = 16x |
| sample_tick | output | 1 | One-clock pulse per oversampling sample |
| bit_tick | output | 1 | Pulse on the last sample of each bit |
| mid_tick | output | 1 | Pulse on the mid-bit sample |

## Verification
Two events can fall in the same clock: a register write, which restarts the chain, and a sample tick or bit tick that is about to fire. The bench provokes this by issuing low-byte writes at a sweep of offsets against a running short-period divisor. Some of those writes land on the exact clock in which the reference model predicts a tick. The behavioural model applies the restart with priority over the tick. Every clock, each output is compared against the model, so a tick that leaks through, or a sample count that survives the restart, shows as a mismatch.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic {
        SRC_DIVISOR = 1'b0,
        SRC_FRACT   = 1'b1
    } src_mode_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/baud_rate_cfg.sv
module baud_rate_cfg
    import baud_pkg::*;
#(
    parameter int unsigned HALF_W = BYTE_W,
    localparam int unsigned SET_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_we,
    input  logic [HALF_W-1:0] hi_data,
    input  logic              lo_we,
    input  logic [HALF_W-1:0] lo_data,
    input  logic              mode_we,
    input  logic              frac_in,
    input  logic              ovs8_in,
    output logic [SET_W-1:0]  setting,
    output src_mode_e         src_mode,
    output logic              ovs8,
    output logic              restart
);

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
        src_mode_e         mode;
        logic              ovs8;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (hi_we) cfg_d.hi = hi_data;
        if (lo_we) cfg_d.lo = lo_data;
        if (mode_we) begin
            cfg_d.mode = frac_in ? SRC_FRACT : SRC_DIVISOR;
            cfg_d.ovs8 = ovs8_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{hi: '0, lo: '0, mode: SRC_DIVISOR, ovs8: 1'b0};
        else        cfg_q <= cfg_d;
    end

    assign setting  = {cfg_q.hi, cfg_q.lo};
    assign src_mode = cfg_q.mode;
    assign ovs8     = cfg_q.ovs8;
    assign restart  = hi_we | lo_we | mode_we;

    // R1
    upper_half_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we && !hi_we) |=> $stable(setting[SET_W-1:HALF_W]));

endmodule

// File: rtl/baud_tick_src.sv
module baud_tick_src
    import baud_pkg::*;
#(
    parameter int unsigned ACC_W = 2 * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  src_mode_e        src_mode,
    input  logic [ACC_W-1:0] setting,
    output logic             sample_tick
);

    typedef struct packed {
        logic [ACC_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
        logic             tick;
    } src_t;

    src_t src_d, src_q;
    logic [ACC_W:0] acc_sum;

    always_comb begin
        acc_sum = {1'b0, src_q.acc} + {1'b0, setting};
        src_d   = '{cnt: '0, acc: '0, tick: 1'b0};
        if (enable && !restart) begin
            if (src_mode == SRC_FRACT) begin
                src_d.acc  = acc_sum[ACC_W-1:0];
                src_d.tick = acc_sum[ACC_W];
            end else if (src_q.cnt >= setting) begin
                src_d.tick = 1'b1;
            end else begin
                src_d.cnt = src_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '{cnt: '0, acc: '0, tick: 1'b0};
        else        src_q <= src_d;
    end

    assign sample_tick = src_q.tick;

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sample_tick);

    // R8
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !sample_tick);

    // R2
    divisor_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && src_mode == SRC_DIVISOR && setting != '0 && !restart)
        |=> !sample_tick);

endmodule

// File: rtl/baud_bit_counter.sv
module baud_bit_counter #(
    parameter int unsigned OVS_HI = 16,
    parameter int unsigned OVS_LO = 8,
    localparam int unsigned CNT_W = $clog2(OVS_HI)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic restart,
    input  logic ovs8,
    input  logic sample_tick,
    output logic bit_tick,
    output logic mid_tick
);

    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(OVS_HI - 1);
    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(OVS_LO - 1);
    localparam logic [CNT_W-1:0] MID_HI  = CNT_W'(OVS_HI / 2 - 1);
    localparam logic [CNT_W-1:0] MID_LO  = CNT_W'(OVS_LO / 2 - 1);

    logic [CNT_W-1:0] samp_d, samp_q;
    logic [CNT_W-1:0] last_idx, mid_idx;

    always_comb begin
        last_idx = ovs8 ? LAST_LO : LAST_HI;
        mid_idx  = ovs8 ? MID_LO  : MID_HI;
        samp_d   = samp_q;
        if (!enable || restart)     samp_d = '0;
        else if (sample_tick)       samp_d = (samp_q >= last_idx) ? '0 : samp_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) samp_q <= '0;
        else        samp_q <= samp_d;
    end

    assign bit_tick = sample_tick && (samp_q == last_idx);
    assign mid_tick = sample_tick && (samp_q == mid_idx);

    // R9
    bit_mid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_tick && mid_tick));

    // R5
    bit_then_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && enable && !restart) |=> (samp_q == '0));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int unsigned HALF_W = BYTE_W,
    parameter int unsigned OVS_HI = 16,
    parameter int unsigned OVS_LO = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rate_hi_we,
    input  logic [HALF_W-1:0] rate_hi_data,
    input  logic              rate_lo_we,
    input  logic [HALF_W-1:0] rate_lo_data,
    input  logic              mode_we,
    input  logic              frac_sel,
    input  logic              ovs8_sel,
    output logic              sample_tick,
    output logic              bit_tick,
    output logic              mid_tick
);

    localparam int unsigned SET_W = 2 * HALF_W;

    logic [SET_W-1:0] setting;
    src_mode_e        src_mode;
    logic             ovs8;
    logic             restart;

    baud_rate_cfg #(.HALF_W(HALF_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .hi_we(rate_hi_we), .hi_data(rate_hi_data),
        .lo_we(rate_lo_we), .lo_data(rate_lo_data),
        .mode_we(mode_we), .frac_in(frac_sel), .ovs8_in(ovs8_sel),
        .setting(setting), .src_mode(src_mode), .ovs8(ovs8), .restart(restart)
    );

    baud_tick_src #(.ACC_W(SET_W)) u_src (
        .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart),
        .src_mode(src_mode), .setting(setting), .sample_tick(sample_tick)
    );

    baud_bit_counter #(.OVS_HI(OVS_HI), .OVS_LO(OVS_LO)) u_bits (
        .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart),
        .ovs8(ovs8), .sample_tick(sample_tick),
        .bit_tick(bit_tick), .mid_tick(mid_tick)
    );

    // R9
    bit_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick || mid_tick) |-> sample_tick);

endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic rate_hi_we = 1'b0, rate_lo_we = 1'b0, mode_we = 1'b0;
    logic [7:0] rate_hi_data = '0, rate_lo_data = '0;
    logic frac_sel = 1'b0, ovs8_sel = 1'b0;
    logic sample_tick, bit_tick, mid_tick;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase = "R6";

    // behavioural reference state
    int m_set = 0, m_frac = 0, m_ovs8 = 0;
    int m_cnt = 0, m_acc = 0, m_tick = 0, m_samp = 0;

    always #2.5 clk = ~clk;

    baud_tick_gen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .rate_hi_we(rate_hi_we), .rate_hi_data(rate_hi_data),
        .rate_lo_we(rate_lo_we), .rate_lo_data(rate_lo_data),
        .mode_we(mode_we), .frac_sel(frac_sel), .ovs8_sel(ovs8_sel),
        .sample_tick(sample_tick), .bit_tick(bit_tick), .mid_tick(mid_tick)
    );

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_set = 0; m_frac = 0; m_ovs8 = 0;
            m_cnt = 0; m_acc = 0; m_tick = 0; m_samp = 0;
        end else begin
            int rs, n_cnt, n_acc, n_tick, n_samp, per, s;
            rs = (rate_hi_we || rate_lo_we || mode_we) ? 1 : 0;
            per = m_ovs8 ? 8 : 16;
            n_cnt = 0; n_acc = 0; n_tick = 0;
            if (enable && rs == 0) begin
                if (m_frac != 0) begin
                    s = m_acc + m_set;
                    n_tick = (s >= 65536) ? 1 : 0;
                    n_acc = s % 65536;
                end else if (m_cnt >= m_set) n_tick = 1;
                else n_cnt = m_cnt + 1;
            end
            if (!enable || rs != 0) n_samp = 0;
            else if (m_tick != 0) n_samp = (m_samp == per - 1) ? 0 : m_samp + 1;
            else n_samp = m_samp;
            if (rate_hi_we) m_set = (m_set % 256) + 256 * int'(rate_hi_data);
            if (rate_lo_we) m_set = (m_set / 256) * 256 + int'(rate_lo_data);
            if (mode_we) begin m_frac = int'(frac_sel); m_ovs8 = int'(ovs8_sel); end
            m_cnt = n_cnt; m_acc = n_acc; m_tick = n_tick; m_samp = n_samp;
        end
    end

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            int per;
            logic eb, em;
            per = m_ovs8 ? 8 : 16;
            eb = (m_tick != 0 && m_samp == per - 1);
            em = (m_tick != 0 && m_samp == per / 2 - 1);
            check(phase, "sample_tick", sample_tick, m_tick != 0);
            check(phase, "bit_tick", bit_tick, eb);
            check(phase, "mid_tick", mid_tick, em);
            // R9: exclusivity and sample dependence at the ports
            check("R9", "bit&mid or orphan", (bit_tick && mid_tick) || ((bit_tick || mid_tick) && !sample_tick), 1'b0);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_hi(logic [7:0] v);
        @(negedge clk); rate_hi_we = 1'b1; rate_hi_data = v;
        @(negedge clk); rate_hi_we = 1'b0;
    endtask

    task automatic wr_lo(logic [7:0] v);
        @(negedge clk); rate_lo_we = 1'b1; rate_lo_data = v;
        @(negedge clk); rate_lo_we = 1'b0;
    endtask

    task automatic wr_mode(logic f, logic o);
        @(negedge clk); mode_we = 1'b1; frac_sel = f; ovs8_sel = o;
        @(negedge clk); mode_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R6: reset state and default 16x divisor with setting 0
        phase = "R6";
        idle(4);
        enable = 1'b1;
        idle(70);
        // R2: divisor periods
        phase = "R2";
        wr_lo(8'd4);
        idle(200);
        wr_lo(8'd1);
        idle(100);
        // R1: halves written separately
        phase = "R1";
        wr_lo(8'd3);
        wr_hi(8'd1);
        idle(600);
        wr_hi(8'd0);
        idle(60);
        // R4 / R3: fractional mode
        phase = "R4";
        wr_mode(1'b1, 1'b0);
        wr_hi(8'h40); wr_lo(8'h00);
        idle(150);
        phase = "R3";
        wr_hi(8'h60); wr_lo(8'h00);
        idle(300);
        wr_hi(8'h00); wr_lo(8'h00);
        idle(40);
        wr_hi(8'hFF); wr_lo(8'hFF);
        idle(80);
        // R5: 8x oversampling in both modes
        phase = "R5";
        wr_mode(1'b1, 1'b1);
        wr_hi(8'h80); wr_lo(8'h00);
        idle(120);
        wr_mode(1'b0, 1'b1);
        wr_hi(8'h00); wr_lo(8'h02);
        idle(120);
        // R7: enable gating and clean restart
        phase = "R7";
        idle(5);
        enable = 1'b0;
        idle(20);
        enable = 1'b1;
        idle(50);
        enable = 1'b0;
        idle(1);
        enable = 1'b1;
        idle(40);
        // R8: writes landing on every phase of a running tick train
        phase = "R8";
        wr_mode(1'b0, 1'b0);
        wr_lo(8'd0);
        for (int k = 0; k < 24; k++) begin
            idle(k + 10);
            wr_lo(8'd0);
        end
        wr_mode(1'b1, 1'b1);
        wr_hi(8'hC0);
        for (int k = 0; k < 12; k++) begin
            idle(k + 3);
            wr_mode(1'b1, 1'b1);
        end
        idle(30);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule